// File: doc/BRIEF.md
# Standby Release and Wake-Stall Sequencer

This block decides which low-power mode the core is in and when the core may run again after a wake-up. Software asks for a mode change through a one-cycle request. The block then gates the fast (fc) and slow (fs) clock domains and raises a CPU halt and a peripheral halt. It leaves a mode when a qualified wake event arrives: the release pin, a key wake-up line, an enabled interrupt request, or a falling edge of the time-base tick.

After a wake the block can hold the CPU for a stabilisation stall, while the peripherals stay clocked. The stall is 2^N ticks of the domain that the resumed mode runs on. A power-down control bit decides whether a given exit stalls at all: exits from deep stop stall when the bit is 1, and exits from the doze modes stall when it is 0. Reset always starts a boot stall, counted in fc ticks, in which the peripherals are frozen as well.

Interrupt requests are latched in every phase. An interrupt can be serviced only while the CPU is running, so a request that arrives during a stall is taken once the stall is over.

Top module: `stby_seq`

## Requirements
- R1: During reset and the boot stall that follows it, `cpu_halt` and `periph_halt` are both 1, `mode_o` is 0 (fast run) and both clock enables are 1. The boot stall ends on the 2^RST_WAIT_LOG2-th `fc_tick` after reset is released; `fs_tick` does not advance it.
- R2: Mode codes are: 0 fast run, 1 slow run, 2 deep stop, 3/4/5 fast doze 0/1/2, 6/7/8 slow doze 0/1/2. A request is accepted only while the CPU runs. From fast run the accepted targets are 1, 2 and 3..5; from slow run they are 0, 2 and 6..8. Any other request leaves `mode_o` unchanged. The only mode change allowed while running is between fast and slow run.
- R3: Deep stop is left when `stop_pin` or any `key_wake` bit is 1. It resumes the run mode it was entered from. With `pd_ctl`=1 it first stalls for 2^FC_WAIT_LOG2 `fc_tick` (resuming fast run) or 2^FS_WAIT_LOG2 `fs_tick` (resuming slow run). With `pd_ctl`=0 the CPU runs on the cycle after the wake.
- R4: A fast doze resumes fast run and a slow doze resumes slow run. With `pd_ctl`=0 the exit stalls for 2^FC_WAIT_LOG2 `fc_tick` or 2^FS_WAIT_LOG2 `fs_tick` respectively; ticks of the other domain do not count. With `pd_ctl`=1 the CPU runs on the cycle after the wake.
- R5: During a wake stall `cpu_halt`=1 and `periph_halt`=0. In deep stop both are 1. In the doze modes only `cpu_halt` is 1.
- R6: Fast doze 0 and slow doze 0 are left only on a 1-to-0 transition of `tbt_in`. Enabled interrupt requests do not release them.
- R7: Doze 1 and doze 2 (fast and slow) are left when any bit of `irq_req & irq_en` is 1. A request whose enable bit is 0, and `tbt_in` edges, do not release them.
- R8: Clock enables {`fc_en`,`fs_en`} per mode are: fast run {1,1}, slow run {0,1}, deep stop {0,0}, doze 0/1 fast {1,0}, doze 0/1 slow {0,1}, doze 2 of either kind {1,1}.
- R9: An `irq_pend` bit is set by its `irq_req` bit in any phase and cleared by its `irq_ack` bit; a request wins over an acknowledge in the same cycle. `irq_service` is 1 only while the CPU runs, `imf` is 1 and some pending bit is enabled. A request latched during a stall is therefore serviced right after the stall.
- R10: `cpu_run` is a single-cycle pulse. It rises in the first running cycle after every boot stall, wake stall or wake without a stall.
- R11: A reset in any mode returns `mode_o` to fast run and restarts the boot stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_tick | input | 1 | One-cycle strobe per fast-domain clock period |
| fs_tick | input | 1 | One-cycle strobe per slow-domain clock period |
| mode_req_valid | input | 1 | Mode-change request strobe |
| mode_sel | input | 4 | Requested mode code (R2) |
| pd_ctl | input | 1 | Power-down control bit choosing which exits stall |
| stop_pin | input | 1 | Release pin for deep stop |
| key_wake | input | NK | Key wake-up lines for deep stop |
| tbt_in | input | 1 | Time-base tick output; its falling edge releases doze 0 |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Individual interrupt enables |
| irq_ack | input | NIRQ | Clears latched requests |
| imf | input | 1 | Master interrupt enable |
| cpu_halt | output | 1 | CPU held |
| periph_halt | output | 1 | Peripherals held |
| fc_en | output | 1 | Fast clock domain enable |
| fs_en | output | 1 | Slow clock domain enable |
| cpu_run | output | 1 | Pulse marking the end of a stall |
| mode_o | output | 4 | Current mode code |
| irq_pend | output | NIRQ | Latched interrupt requests |
| irq_service | output | 1 | Interrupt may be taken now |

## Verification
The bench drives each clock-domain tick by hand. It stops one tick short of every stall length and checks that the CPU is still held, then gives the last tick. A counter off by one, or one that counts in the wrong domain, shows up as an early or late release. Deep-stop exits are checked with both settings of the power-down bit. A design that applied the bit with the wrong polarity would stall the wrong exit or skip a stall it owes.

The doze 0 modes are hit with enabled interrupts, and the doze 1 modes with disabled requests and tick edges. Confusing the wake sources would let the core out early. An interrupt latched mid-stall must stay pending and be serviced only after release; a design that serviced it during the stall, or dropped it, is caught here. Two more checks cover software asking for a mode that the current clock cannot support, and a reset applied mid-doze.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [3:0] {
        PM_RUN_FAST  = 4'd0,
        PM_RUN_SLOW  = 4'd1,
        PM_DEEP_STOP = 4'd2,
        PM_FDOZE0    = 4'd3,
        PM_FDOZE1    = 4'd4,
        PM_FDOZE2    = 4'd5,
        PM_SDOZE0    = 4'd6,
        PM_SDOZE1    = 4'd7,
        PM_SDOZE2    = 4'd8
    } pmode_e;

    typedef enum logic [1:0] {
        PH_BOOT,    // boot stall after reset
        PH_ACTIVE,  // CPU running
        PH_PARKED,  // in a low-power mode awaiting wake
        PH_SETTLE   // post-wake stall
    } phase_e;

    function automatic logic is_fdoze(input pmode_e m);
        return (m == PM_FDOZE0) || (m == PM_FDOZE1) || (m == PM_FDOZE2);
    endfunction

    function automatic logic is_sdoze(input pmode_e m);
        return (m == PM_SDOZE0) || (m == PM_SDOZE1) || (m == PM_SDOZE2);
    endfunction

    function automatic logic is_doze_tbt(input pmode_e m);
        return (m == PM_FDOZE0) || (m == PM_SDOZE0);
    endfunction

endpackage

// File: rtl/stby_wake_src.sv
module stby_wake_src #(
    parameter int NK   = 4,
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tbt_in,
    input  logic            stop_pin,
    input  logic [NK-1:0]   key_wake,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    output logic            tbt_fall,
    output logic            pin_wake,
    output logic            irq_wake
);
    logic tbt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbt_q <= 1'b0;
        else        tbt_q <= tbt_in;
    end

    always_comb begin
        tbt_fall = tbt_q & ~tbt_in;
        pin_wake = stop_pin | (|key_wake);
        irq_wake = |(irq_req & irq_en);
    end
endmodule

// File: rtl/stby_settle_ctr.sv
module stby_settle_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] last,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = tick && (cnt_q == last);
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (done) cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/stby_clk_map.sv
module stby_clk_map
    import stby_pkg::*;
(
    input  pmode_e mode,
    output logic   fc_en,
    output logic   fs_en
);
    always_comb begin
        unique case (mode)
            PM_RUN_FAST:             begin fc_en = 1'b1; fs_en = 1'b1; end
            PM_RUN_SLOW:             begin fc_en = 1'b0; fs_en = 1'b1; end
            PM_DEEP_STOP:            begin fc_en = 1'b0; fs_en = 1'b0; end
            PM_FDOZE0, PM_FDOZE1:    begin fc_en = 1'b1; fs_en = 1'b0; end
            PM_SDOZE0, PM_SDOZE1:    begin fc_en = 1'b0; fs_en = 1'b1; end
            PM_FDOZE2, PM_SDOZE2:    begin fc_en = 1'b1; fs_en = 1'b1; end
            default:                 begin fc_en = 1'b1; fs_en = 1'b1; end
        endcase
    end
endmodule

// File: rtl/stby_irq_latch.sv
module stby_irq_latch #(
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_ack,
    output logic [NIRQ-1:0] irq_pend
);
    for (genvar i = 0; i < NIRQ; i++) begin : g_bit
        logic pend_d, pend_q;
        always_comb pend_d = (pend_q & ~irq_ack[i]) | irq_req[i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= pend_d;
        end
        assign irq_pend[i] = pend_q;
    end
endmodule

// File: rtl/stby_seq.sv
module stby_seq
    import stby_pkg::*;
#(
    parameter int NK            = 4,
    parameter int NIRQ          = 8,
    parameter int FC_WAIT_LOG2  = 4,
    parameter int FS_WAIT_LOG2  = 3,
    parameter int RST_WAIT_LOG2 = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fc_tick,
    input  logic            fs_tick,
    input  logic            mode_req_valid,
    input  logic [3:0]      mode_sel,
    input  logic            pd_ctl,
    input  logic            stop_pin,
    input  logic [NK-1:0]   key_wake,
    input  logic            tbt_in,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_en,
    input  logic [NIRQ-1:0] irq_ack,
    input  logic            imf,
    output logic            cpu_halt,
    output logic            periph_halt,
    output logic            fc_en,
    output logic            fs_en,
    output logic            cpu_run,
    output logic [3:0]      mode_o,
    output logic [NIRQ-1:0] irq_pend,
    output logic            irq_service
);
    localparam int MAXL_A = (FC_WAIT_LOG2 > FS_WAIT_LOG2) ? FC_WAIT_LOG2 : FS_WAIT_LOG2;
    localparam int MAXL   = (MAXL_A > RST_WAIT_LOG2) ? MAXL_A : RST_WAIT_LOG2;
    localparam int CW     = MAXL + 1;
    localparam logic [CW-1:0] FC_LAST  = CW'((64'd1 << FC_WAIT_LOG2) - 64'd1);
    localparam logic [CW-1:0] FS_LAST  = CW'((64'd1 << FS_WAIT_LOG2) - 64'd1);
    localparam logic [CW-1:0] RST_LAST = CW'((64'd1 << RST_WAIT_LOG2) - 64'd1);

    typedef struct packed {
        phase_e phase;
        pmode_e mode;
        logic   resume_slow;
        logic   sel_fs;
        logic   run_pulse;
    } seq_t;

    seq_t s_d, s_q;

    logic          tbt_fall, pin_wake, irq_wake;
    logic          ctr_clear, ctr_tick, ctr_done;
    logic [CW-1:0] ctr_last;
    pmode_e        req_mode, target;
    logic          wake, need_stall;

    stby_wake_src #(.NK(NK), .NIRQ(NIRQ)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .tbt_in   (tbt_in),
        .stop_pin (stop_pin),
        .key_wake (key_wake),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .tbt_fall (tbt_fall),
        .pin_wake (pin_wake),
        .irq_wake (irq_wake)
    );

    stby_settle_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctr_clear),
        .tick  (ctr_tick),
        .last  (ctr_last),
        .done  (ctr_done)
    );

    stby_irq_latch #(.NIRQ(NIRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .irq_ack  (irq_ack),
        .irq_pend (irq_pend)
    );

    stby_clk_map u_clk (
        .mode  (s_q.mode),
        .fc_en (fc_en),
        .fs_en (fs_en)
    );

    // counter feed: boot stall always counts fc; wake stall counts the resumed domain
    always_comb begin
        ctr_tick = ((s_q.phase == PH_BOOT) || (s_q.phase == PH_SETTLE)) &&
                   (s_q.sel_fs ? fs_tick : fc_tick);
        if (s_q.phase == PH_BOOT) ctr_last = RST_LAST;
        else if (s_q.sel_fs)      ctr_last = FS_LAST;
        else                      ctr_last = FC_LAST;
    end

    // wake qualification and resume target for the mode currently parked in
    always_comb begin
        req_mode = pmode_e'(mode_sel);
        if (s_q.mode == PM_DEEP_STOP)   wake = pin_wake;
        else if (is_doze_tbt(s_q.mode)) wake = tbt_fall;
        else                            wake = irq_wake;

        if (s_q.mode == PM_DEEP_STOP)
            target = s_q.resume_slow ? PM_RUN_SLOW : PM_RUN_FAST;
        else if (is_fdoze(s_q.mode))
            target = PM_RUN_FAST;
        else
            target = PM_RUN_SLOW;

        need_stall = (s_q.mode == PM_DEEP_STOP) ? pd_ctl : ~pd_ctl;
    end

    always_comb begin
        s_d           = s_q;
        s_d.run_pulse = 1'b0;
        ctr_clear     = 1'b0;

        unique case (s_q.phase)
            PH_BOOT: begin
                if (ctr_done) begin
                    s_d.phase     = PH_ACTIVE;
                    s_d.run_pulse = 1'b1;
                end
            end
            PH_ACTIVE: begin
                if (mode_req_valid) begin
                    if (s_q.mode == PM_RUN_FAST) begin
                        if (req_mode == PM_RUN_SLOW) begin
                            s_d.mode = PM_RUN_SLOW;
                        end else if (req_mode == PM_DEEP_STOP) begin
                            s_d.mode        = PM_DEEP_STOP;
                            s_d.resume_slow = 1'b0;
                            s_d.phase       = PH_PARKED;
                        end else if (is_fdoze(req_mode)) begin
                            s_d.mode  = req_mode;
                            s_d.phase = PH_PARKED;
                        end
                    end else if (s_q.mode == PM_RUN_SLOW) begin
                        if (req_mode == PM_RUN_FAST) begin
                            s_d.mode = PM_RUN_FAST;
                        end else if (req_mode == PM_DEEP_STOP) begin
                            s_d.mode        = PM_DEEP_STOP;
                            s_d.resume_slow = 1'b1;
                            s_d.phase       = PH_PARKED;
                        end else if (is_sdoze(req_mode)) begin
                            s_d.mode  = req_mode;
                            s_d.phase = PH_PARKED;
                        end
                    end
                end
            end
            PH_PARKED: begin
                if (wake) begin
                    s_d.mode   = target;
                    s_d.sel_fs = (target == PM_RUN_SLOW);
                    if (need_stall) begin
                        s_d.phase = PH_SETTLE;
                        ctr_clear = 1'b1;
                    end else begin
                        s_d.phase     = PH_ACTIVE;
                        s_d.run_pulse = 1'b1;
                    end
                end
            end
            PH_SETTLE: begin
                if (ctr_done) begin
                    s_d.phase     = PH_ACTIVE;
                    s_d.run_pulse = 1'b1;
                end
            end
            default: s_d.phase = PH_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase       <= PH_BOOT;
            s_q.mode        <= PM_RUN_FAST;
            s_q.resume_slow <= 1'b0;
            s_q.sel_fs      <= 1'b0;
            s_q.run_pulse   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cpu_halt    = (s_q.phase != PH_ACTIVE);
        periph_halt = (s_q.phase == PH_BOOT) ||
                      ((s_q.phase == PH_PARKED) && (s_q.mode == PM_DEEP_STOP));
        cpu_run     = s_q.run_pulse;
        mode_o      = s_q.mode;
        irq_service = (s_q.phase == PH_ACTIVE) && imf && (|(irq_pend & irq_en));
    end
endmodule

// File: rtl/stby_seq_chk.sv
module stby_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_halt,
    input logic       periph_halt,
    input logic       fc_en,
    input logic       fs_en,
    input logic       cpu_run,
    input logic [3:0] mode_o,
    input logic       irq_service
);
    // R10
    cpu_run_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_run |-> (!cpu_halt && $past(cpu_halt)));

    // R5
    periph_needs_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_halt |-> cpu_halt);

    // R9
    service_while_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_service |-> !cpu_halt);

    // R8
    stop_clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_halt && mode_o == 4'd2) |-> (!fc_en && !fs_en));

    // R1
    boot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_halt && mode_o != 4'd2) |-> (mode_o == 4'd0 && fc_en && fs_en));

    // R2
    run_mode_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_halt && $past(!cpu_halt) && mode_o != $past(mode_o)) |-> (mode_o <= 4'd1));
endmodule

bind stby_seq stby_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_halt    (cpu_halt),
    .periph_halt (periph_halt),
    .fc_en       (fc_en),
    .fs_en       (fs_en),
    .cpu_run     (cpu_run),
    .mode_o      (mode_o),
    .irq_service (irq_service)
);

// File: tb/tb_stby_seq.sv
module tb_stby_seq;
    localparam int CLK_P  = 10;
    localparam int NK     = 4;
    localparam int NIRQ   = 8;
    localparam int FCL    = 3;
    localparam int FSL    = 2;
    localparam int RSTL   = 4;
    localparam int FC_LEN = 1 << FCL;
    localparam int FS_LEN = 1 << FSL;
    localparam int RS_LEN = 1 << RSTL;

    localparam logic [3:0] M_FAST = 4'd0, M_SLOW = 4'd1, M_STOP = 4'd2,
                           M_FD0 = 4'd3, M_FD1 = 4'd4, M_FD2 = 4'd5,
                           M_SD0 = 4'd6, M_SD1 = 4'd7, M_SD2 = 4'd8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fc_tick = 0, fs_tick = 0, mode_req_valid = 0, pd_ctl = 0;
    logic stop_pin = 0, tbt_in = 0, imf = 0;
    logic [3:0] mode_sel = '0;
    logic [NK-1:0] key_wake = '0;
    logic [NIRQ-1:0] irq_req = '0, irq_en = '0, irq_ack = '0;
    logic cpu_halt, periph_halt, fc_en, fs_en, cpu_run, irq_service;
    logic [3:0] mode_o;
    logic [NIRQ-1:0] irq_pend;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    stby_seq #(.NK(NK), .NIRQ(NIRQ), .FC_WAIT_LOG2(FCL), .FS_WAIT_LOG2(FSL),
               .RST_WAIT_LOG2(RSTL)) dut (
        .clk(clk), .rst_n(rst_n), .fc_tick(fc_tick), .fs_tick(fs_tick),
        .mode_req_valid(mode_req_valid), .mode_sel(mode_sel), .pd_ctl(pd_ctl),
        .stop_pin(stop_pin), .key_wake(key_wake), .tbt_in(tbt_in),
        .irq_req(irq_req), .irq_en(irq_en), .irq_ack(irq_ack), .imf(imf),
        .cpu_halt(cpu_halt), .periph_halt(periph_halt), .fc_en(fc_en),
        .fs_en(fs_en), .cpu_run(cpu_run), .mode_o(mode_o),
        .irq_pend(irq_pend), .irq_service(irq_service));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick_fc(input int n);
        for (int i = 0; i < n; i++) begin fc_tick = 1; step(); fc_tick = 0; end
    endtask

    task automatic tick_fs(input int n);
        for (int i = 0; i < n; i++) begin fs_tick = 1; step(); fs_tick = 0; end
    endtask

    task automatic request(input logic [3:0] m);
        mode_sel = m; mode_req_valid = 1; step(); mode_req_valid = 0;
    endtask

    task automatic pulse_irq(input int b);
        irq_req[b] = 1; step(); irq_req[b] = 0;
    endtask

    task automatic clear_irq();
        irq_ack = '1; step(); irq_ack = '0;
    endtask

    task automatic run_boot(input string tag);
        chk({tag, " boot cpu_halt"}, cpu_halt, 1);
        chk({tag, " boot periph_halt"}, periph_halt, 1);
        chk({tag, " boot mode"}, mode_o, 0);
        chk({tag, " boot clocks"}, {fc_en, fs_en}, 3);
        tick_fs(RS_LEN + 2);
        tick_fc(RS_LEN - 1);
        chk({tag, " still held one tick short"}, {cpu_halt, periph_halt}, 3);
        tick_fc(1);
        chk({tag, " released"}, {cpu_halt, periph_halt}, 0);
        chk({tag, " R10 run pulse"}, cpu_run, 1);
        step();
        chk({tag, " R10 run pulse single"}, cpu_run, 0);
    endtask

    task automatic t_reset();
        rst_n = 0; step(); step();
        rst_n = 1;
        run_boot("R1");
    endtask

    task automatic t_mode_legal();
        request(M_SD1);
        chk("R2 slow doze refused from fast run", {28'd0, mode_o, cpu_halt}, 0);
        request(4'd12);
        chk("R2 undefined code ignored", mode_o, 0);
        request(M_SLOW);
        chk("R2 switch to slow run", mode_o, 1);
        chk("R8 slow run clocks", {fc_en, fs_en}, 1);
        request(M_FD2);
        chk("R2 fast doze refused from slow run", {28'd0, mode_o, cpu_halt}, 2);
        request(M_FAST);
        chk("R2 back to fast run", mode_o, 0);
        chk("R8 fast run clocks", {fc_en, fs_en}, 3);
    endtask

    task automatic t_stop();
        pd_ctl = 1;
        request(M_STOP);
        chk("R5 stop halts", {cpu_halt, periph_halt}, 3);
        chk("R8 stop clocks", {fc_en, fs_en}, 0);
        tbt_in = 1; step(); tbt_in = 0; step();
        chk("R3 stop ignores tbt", cpu_halt, 1);
        key_wake[2] = 1; step(); key_wake[2] = 0;
        chk("R3 key wake to fast run", mode_o, 0);
        chk("R5 stall keeps peripherals", {cpu_halt, periph_halt}, 2);
        tick_fs(FC_LEN + 1);
        tick_fc(FC_LEN - 1);
        chk("R3 fc stall one short", cpu_halt, 1);
        tick_fc(1);
        chk("R3 fc stall done", {cpu_halt, cpu_run}, 1);
        request(M_SLOW);
        request(M_STOP);
        stop_pin = 1; step(); stop_pin = 0;
        chk("R3 pin wake resumes slow run", mode_o, 1);
        tick_fc(FS_LEN + 2);
        tick_fs(FS_LEN - 1);
        chk("R3 fs stall one short", cpu_halt, 1);
        tick_fs(1);
        chk("R3 fs stall done", {cpu_halt, cpu_run}, 1);
        pd_ctl = 0;
        request(M_STOP);
        stop_pin = 1; step(); stop_pin = 0;
        chk("R3 no stall when bit clear", {cpu_halt, cpu_run, mode_o}, 6'b01_0001);
        request(M_FAST);
    endtask

    task automatic t_doze_stall();
        pd_ctl = 0; irq_en = 8'h01;
        request(M_FD2);
        chk("R8 fast doze 2 clocks", {fc_en, fs_en}, 3);
        chk("R5 doze halts cpu only", {cpu_halt, periph_halt}, 2);
        pulse_irq(0);
        tick_fc(FC_LEN - 1);
        chk("R4 fast doze stall one short", cpu_halt, 1);
        tick_fc(1);
        chk("R4 fast doze stall done", {cpu_halt, cpu_run, mode_o}, 6'b01_0000);
        clear_irq();
        pd_ctl = 1;
        request(M_FD1);
        chk("R8 fast doze 1 clocks", {fc_en, fs_en}, 2);
        pulse_irq(0);
        chk("R4 no stall when bit set", {cpu_halt, cpu_run}, 1);
        clear_irq();
        pd_ctl = 0;
        request(M_SLOW);
        request(M_SD1);
        chk("R8 slow doze 1 clocks", {fc_en, fs_en}, 1);
        pulse_irq(0);
        tick_fc(FS_LEN + 1);
        tick_fs(FS_LEN - 1);
        chk("R4 slow doze stall one short", cpu_halt, 1);
        tick_fs(1);
        chk("R4 slow doze stall done", {cpu_halt, mode_o}, 1);
        clear_irq();
        request(M_FAST);
        irq_en = '0;
    endtask

    task automatic t_doze0();
        pd_ctl = 1; irq_en = '1;
        request(M_FD0);
        pulse_irq(4);
        chk("R6 interrupt does not release doze 0", cpu_halt, 1);
        tbt_in = 1; step();
        chk("R6 rising tick does not release", cpu_halt, 1);
        tbt_in = 0; step();
        chk("R6 falling tick releases", {cpu_halt, cpu_run}, 1);
        clear_irq();
        irq_en = '0;
    endtask

    task automatic t_doze12();
        pd_ctl = 1; irq_en = '0;
        request(M_FD1);
        irq_req[3] = 1; step();
        chk("R7 disabled request does not release", cpu_halt, 1);
        tbt_in = 1; step(); tbt_in = 0; step();
        chk("R7 tick edge does not release", cpu_halt, 1);
        irq_en[3] = 1; step();
        irq_req[3] = 0;
        chk("R7 enabled request releases", {cpu_halt, cpu_run}, 1);
        clear_irq();
        irq_en = '0;
    endtask

    task automatic t_irq_latch();
        imf = 0;
        pulse_irq(5);
        chk("R9 request latched", irq_pend[5], 1);
        #1 chk("R9 no service without master enable", irq_service, 0);
        imf = 1; irq_en[5] = 1;
        #1 chk("R9 service when enabled", irq_service, 1);
        irq_req[5] = 1; irq_ack[5] = 1; step();
        irq_req[5] = 0; irq_ack[5] = 0;
        chk("R9 request wins over ack", irq_pend[5], 1);
        clear_irq();
        chk("R9 ack clears", irq_pend[5], 0);
        pd_ctl = 0;
        request(M_FD2);
        pulse_irq(5);
        #1 chk("R9 no service during stall", irq_service, 0);
        tick_fc(FC_LEN);
        #1 chk("R9 serviced after stall", {cpu_halt, irq_service}, 1);
        clear_irq();
        imf = 0; irq_en = '0;
    endtask

    task automatic t_reset_mid();
        pd_ctl = 0;
        request(M_SLOW);
        request(M_SD2);
        rst_n = 0; #1;
        chk("R11 reset restores fast run", mode_o, 0);
        step();
        rst_n = 1;
        run_boot("R11");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        step();
        t_reset();
        t_mode_legal();
        t_stop();
        t_doze_stall();
        t_doze0();
        t_doze12();
        t_irq_latch();
        t_reset_mid();
        finish_run();
    end
endmodule